// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash device. After a program or erase command has been issued to the device, the block decides whether the operation has finished. It reads the 8-bit status word in back-to-back pairs over a simple req/ack memory bus and compares the toggle bit of the two reads. It also watches the device's time-limit bit. If the time-limit bit is set and the toggle bit is still moving on a second pair of reads, the operation has failed. In that case the block writes the reset command so the device returns to array reads.

A requesting agent starts a check with a one-cycle `start_i` pulse that carries the address to poll. The agent watches `busy_o` while the check runs. It gets a one-cycle `done_o` pulse with a result code when the check ends. The agent can abort a check to use the bus for other work. A later start always begins again with a fresh pair of reads and a cleared poll count. A host-side limit on the number of polls ends a check that never resolves.

Top module: `tbp_poller`

## Requirements
- R1: After reset `busy_o`, `done_o` and `bus_req_o` are 0 and `result_o` is 0.
- R2: A `start_i` pulse while idle begins a check. Each status check is two consecutive bus reads (`bus_we_o`=0) at the address latched at start. A `start_i` while busy is ignored.
- R3: If bit 6 (the toggle bit) is equal in the two reads of a pair, the check ends with result 0 (complete) and no write is issued.
- R4: If bit 6 differs and bit 5 of the second read of the pair is 0, another pair of reads follows.
- R5: If bit 6 differs and bit 5 of the second read is 1, a recheck pair is read. If bit 6 is equal in the recheck pair, the result is 0 (complete).
- R6: If bit 6 still differs in the recheck pair, one bus write of 0xF0 (`bus_we_o`=1) to the polled address is issued. After its ack the check ends with result 1 (device failure).
- R7: When MAX_POLLS pairs in a row have toggled with bit 5 at 0, the check ends with result 2 (host timeout) and no write is issued.
- R8: `bus_req_o` stays high until `bus_ack_i`. While a request waits, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` do not change.
- R9: An `abort_i` pulse during reads takes effect when the current read is acked. The block then goes idle with no `done_o`, and the next start begins with a fresh pair and a cleared poll count. An abort during the reset write is ignored.
- R10: `done_o` is a one-cycle pulse. `busy_o` is 0 in that cycle, and `result_o` holds its value until the next check ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a completion check |
| abort_i | input | 1 | Abandon the running check |
| op_addr_i | input | AW | Address to poll, sampled on start |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle end-of-check pulse |
| result_o | output | 2 | 0 complete, 1 device failure, 2 host timeout |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transaction complete |
| bus_rdata_i | input | 8 | Read data, valid with ack |

## Verification
The hardest case to reach is a toggle bit that keeps moving after the time-limit bit rises. Close behind it is a toggle bit that stops exactly on the recheck pair, since the two differ only in which read the toggling ends on. The bench drives a device model parameterised by the read index where toggling stops and the index where bit 5 rises. Directed values put those indices on both sides of each pair boundary and at the poll limit. Random values sweep the rest, and random ack delays stretch each transaction.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int STATUS_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RC_A,
    ST_RC_B,
    ST_WR_RST
  } tbp_state_e;

  localparam logic [1:0] RES_COMPLETE = 2'd0;
  localparam logic [1:0] RES_DEVFAIL  = 2'd1;
  localparam logic [1:0] RES_HOSTTMO  = 2'd2;

  function automatic logic [STATUS_W-1:0] bit_mask(input int pos);
    return STATUS_W'(1) << pos;
  endfunction

  function automatic logic toggle_seen(input logic [STATUS_W-1:0] a,
                                       input logic [STATUS_W-1:0] b,
                                       input logic [STATUS_W-1:0] mask);
    return |((a ^ b) & mask);
  endfunction

  function automatic logic flag_seen(input logic [STATUS_W-1:0] w,
                                     input logic [STATUS_W-1:0] mask);
    return |(w & mask);
  endfunction
endpackage

// File: rtl/tbp_pair_eval.sv
module tbp_pair_eval
  import tbp_pkg::*;
#(
  parameter int TOG_BIT  = 6,
  parameter int FAIL_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_first_i,
  input  logic [STATUS_W-1:0] rdata_i,
  output logic                toggled_o,
  output logic                fail_flag_o
);
  localparam logic [STATUS_W-1:0] TOG_MASK  = bit_mask(TOG_BIT);
  localparam logic [STATUS_W-1:0] FAIL_MASK = bit_mask(FAIL_BIT);

  logic [STATUS_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            first_q <= '0;
    else if (load_first_i) first_q <= rdata_i;
  end

  assign toggled_o   = toggle_seen(first_q, rdata_i, TOG_MASK);
  assign fail_flag_o = flag_seen(rdata_i, FAIL_MASK);
endmodule

// File: rtl/tbp_poll_cnt.sv
module tbp_poll_cnt #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (inc_i)      cnt_q <= cnt_q + 1'b1;
  end

  assign at_last_o = (cnt_q == LAST);
endmodule

// File: rtl/tbp_bus_drv.sv
module tbp_bus_drv
  import tbp_pkg::*;
#(
  parameter int                  AW      = 16,
  parameter logic [STATUS_W-1:0] RST_CMD = 8'hF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tbp_state_e          state_i,
  input  logic                accept_i,
  input  logic [AW-1:0]       op_addr_i,
  output logic                req_o,
  output logic                we_o,
  output logic [AW-1:0]       addr_o,
  output logic [STATUS_W-1:0] wdata_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (accept_i) addr_q <= op_addr_i;
  end

  assign req_o   = (state_i != ST_IDLE);
  assign we_o    = (state_i == ST_WR_RST);
  assign addr_o  = addr_q;
  assign wdata_o = we_o ? RST_CMD : '0;
endmodule

// File: rtl/tbp_seq.sv
module tbp_seq
  import tbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       xfer_i,
  input  logic       toggled_i,
  input  logic       fail_flag_i,
  input  logic       at_last_i,
  output tbp_state_e state_o,
  output logic       accept_o,
  output logic       load_first_o,
  output logic       cnt_inc_o,
  output logic       done_o,
  output logic [1:0] result_o,
  output logic       ev_abort_o,
  output logic       ev_timeout_o
);
  tbp_state_e state_q, state_d;
  logic       abort_pend_q;
  logic       abort_now;
  logic       finish;
  logic [1:0] finish_code;
  logic       done_q;
  logic [1:0] result_q;

  assign abort_now = abort_i | abort_pend_q;
  assign accept_o  = (state_q == ST_IDLE) & start_i;

  always_comb begin
    state_d      = state_q;
    load_first_o = 1'b0;
    cnt_inc_o    = 1'b0;
    finish       = 1'b0;
    finish_code  = RES_COMPLETE;
    ev_abort_o   = 1'b0;
    ev_timeout_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD_A;
      ST_RD_A, ST_RC_A: if (xfer_i) begin
        if (abort_now) begin
          state_d    = ST_IDLE;
          ev_abort_o = 1'b1;
        end else begin
          load_first_o = 1'b1;
          state_d      = (state_q == ST_RD_A) ? ST_RD_B : ST_RC_B;
        end
      end
      ST_RD_B: if (xfer_i) begin
        if (abort_now) begin
          state_d    = ST_IDLE;
          ev_abort_o = 1'b1;
        end else if (!toggled_i) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else if (fail_flag_i) begin
          state_d = ST_RC_A;
        end else if (at_last_i) begin
          state_d      = ST_IDLE;
          finish       = 1'b1;
          finish_code  = RES_HOSTTMO;
          ev_timeout_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
          state_d   = ST_RD_A;
        end
      end
      ST_RC_B: if (xfer_i) begin
        if (abort_now) begin
          state_d    = ST_IDLE;
          ev_abort_o = 1'b1;
        end else if (!toggled_i) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_d = ST_WR_RST;
        end
      end
      ST_WR_RST: if (xfer_i) begin
        state_d     = ST_IDLE;
        finish      = 1'b1;
        finish_code = RES_DEVFAIL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      abort_pend_q <= 1'b0;
      done_q       <= 1'b0;
      result_q     <= RES_COMPLETE;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (finish) result_q <= finish_code;
      if (state_d == ST_IDLE)                           abort_pend_q <= 1'b0;
      else if (abort_i && state_q != ST_IDLE && state_q != ST_WR_RST) abort_pend_q <= 1'b1;
    end
  end

  assign state_o  = state_q;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
  import tbp_pkg::*;
#(
  parameter int                  AW        = 16,
  parameter int                  MAX_POLLS = 64,
  parameter int                  TOG_BIT   = 6,
  parameter int                  FAIL_BIT  = 5,
  parameter logic [STATUS_W-1:0] RST_CMD   = 8'hF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic [AW-1:0]       op_addr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          result_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [AW-1:0]       bus_addr_o,
  output logic [STATUS_W-1:0] bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic [STATUS_W-1:0] bus_rdata_i
);
  tbp_state_e state;
  logic accept, xfer, load_first, cnt_inc, toggled, fail_flag, at_last;
  logic ev_abort, ev_timeout;

  assign xfer   = bus_req_o & bus_ack_i;
  assign busy_o = (state != ST_IDLE);

  tbp_seq u_seq (
    .clk, .rst_n,
    .start_i, .abort_i,
    .xfer_i       (xfer),
    .toggled_i    (toggled),
    .fail_flag_i  (fail_flag),
    .at_last_i    (at_last),
    .state_o      (state),
    .accept_o     (accept),
    .load_first_o (load_first),
    .cnt_inc_o    (cnt_inc),
    .done_o,
    .result_o,
    .ev_abort_o   (ev_abort),
    .ev_timeout_o (ev_timeout)
  );

  tbp_pair_eval #(.TOG_BIT(TOG_BIT), .FAIL_BIT(FAIL_BIT)) u_eval (
    .clk, .rst_n,
    .load_first_i (load_first),
    .rdata_i      (bus_rdata_i),
    .toggled_o    (toggled),
    .fail_flag_o  (fail_flag)
  );

  tbp_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk, .rst_n,
    .clr_i     (accept),
    .inc_i     (cnt_inc),
    .at_last_o (at_last)
  );

  tbp_bus_drv #(.AW(AW), .RST_CMD(RST_CMD)) u_bus (
    .clk, .rst_n,
    .state_i   (state),
    .accept_i  (accept),
    .op_addr_i,
    .req_o     (bus_req_o),
    .we_o      (bus_we_o),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o)
  );
endmodule

// File: rtl/tbp_poller_chk.sv
module tbp_poller_chk #(
  parameter int       AW      = 16,
  parameter logic [7:0] RST_CMD = 8'hF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_ack,
  input logic          ev_abort,
  input logic          ev_timeout,
  input logic          at_last
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !done && !bus_req && result == 2'd0));

  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  a_r3_complete_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd0) |-> $past(!bus_we));

  a_r6_write_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata == RST_CMD));

  a_r6_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd1) |-> $past(bus_req && bus_we && bus_ack));

  a_r7_timeout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> at_last);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!done && !busy));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind tbp_poller tbp_poller_chk #(.AW(AW), .RST_CMD(RST_CMD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_o),
  .done       (done_o),
  .result     (result_o),
  .bus_req    (bus_req_o),
  .bus_we     (bus_we_o),
  .bus_addr   (bus_addr_o),
  .bus_wdata  (bus_wdata_o),
  .bus_ack    (bus_ack_i),
  .ev_abort   (ev_abort),
  .ev_timeout (ev_timeout),
  .at_last    (at_last)
);

// File: tb/sim_tbp_poller.sv
`timescale 1ns/100ps
module sim_tbp_poller;
  localparam int AW = 16;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic abort_i = 1'b0;
  logic [AW-1:0] op_addr_i = '0;
  logic busy_o, done_o, bus_req_o, bus_we_o;
  logic [1:0] result_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0] bus_wdata_o;
  logic bus_ack_i = 1'b0;
  logic [7:0] bus_rdata_i = '0;

  always #2.5 clk = ~clk;

  tbp_poller #(.AW(AW), .MAX_POLLS(MAXP)) u0 (.*);

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // device model state
  int dev_t = 0;
  int dev_f = 0;
  int dev_base = 0;
  int rd_k = 0;
  int wr_n = 0;
  int addr_err = 0;
  int wait_c = 0;
  logic [7:0] wr_last = '0;
  logic [AW-1:0] exp_addr = '0;

  function automatic logic [7:0] dev_status(input int idx);
    logic [7:0] w;
    int m;
    m = (idx < dev_t) ? idx : dev_t;
    w = 8'($urandom);
    w[6] = m[0];
    w[5] = (idx >= dev_f);
    return w;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_ack_i) bus_ack_i <= 1'b0;
    else if (bus_req_o) begin
      if (wait_c == 0) begin
        bus_ack_i <= 1'b1;
        wait_c <= int'($urandom % 4);
        if (bus_addr_o != exp_addr) addr_err <= addr_err + 1;
        if (bus_we_o) begin
          wr_n <= wr_n + 1;
          wr_last <= bus_wdata_o;
        end else begin
          bus_rdata_i <= dev_status(rd_k - dev_base);
          rd_k <= rd_k + 1;
        end
      end else wait_c <= wait_c - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench restatement of the algorithm over read indices
  function automatic void model(input int t, input int f, output int res,
                                output int nrd, output int nwr);
    int k = 0;
    int pairs = 0;
    res = -1;
    nwr = 0;
    while (res < 0) begin
      bit tog, fb;
      tog = (k < t);
      fb = (k + 1 >= f);
      k += 2;
      if (!tog) res = 0;
      else if (!fb) begin
        pairs++;
        if (pairs == MAXP) res = 2;
      end else begin
        tog = (k < t);
        k += 2;
        if (!tog) res = 0;
        else begin res = 1; nwr = 1; end
      end
    end
    nrd = k;
  endfunction

  // mode 0 plain, 1 abort during reset write, 2 extra start while busy
  task automatic run_case(input int t, input int f, input int mode, input string tag);
    int er, en, ew, rb, wb, eb, lim;
    bit seen;
    model(t, f, er, en, ew);
    @(negedge clk);
    dev_t = t; dev_f = f; dev_base = rd_k;
    rb = rd_k; wb = wr_n; eb = addr_err;
    exp_addr = AW'($urandom);
    op_addr_i = exp_addr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    op_addr_i = ~exp_addr;
    seen = 1'b0;
    lim = 0;
    while (!seen && lim < 3000) begin
      if (mode == 2 && lim == 3) start_i = 1'b1;
      else start_i = 1'b0;
      if (mode == 1 && bus_we_o && bus_req_o) abort_i = 1'b1;
      else abort_i = 1'b0;
      @(negedge clk);
      lim++;
      if (done_o) seen = 1'b1;
    end
    start_i = 1'b0;
    abort_i = 1'b0;
    chk(seen, {tag, " done seen R10"}, int'(seen), 1);
    chk(!busy_o, {tag, " R10 idle at done"}, int'(busy_o), 0);
    chk(int'(result_o) == er, {tag, " result R3/R5/R6/R7"}, int'(result_o), er);
    chk(rd_k - rb == en, {tag, " read count R2/R4"}, rd_k - rb, en);
    chk(wr_n - wb == ew, {tag, " write count R6"}, wr_n - wb, ew);
    chk(addr_err == eb, {tag, " address R2"}, addr_err - eb, 0);
    if (ew > 0) chk(wr_last == 8'hF0, {tag, " reset cmd R6"}, int'(wr_last), 240);
    @(negedge clk);
    chk(!done_o, {tag, " done one cycle R10"}, int'(done_o), 0);
    chk(int'(result_o) == er, {tag, " result held R10"}, int'(result_o), er);
  endtask

  task automatic abort_then_restart();
    bit seen;
    @(negedge clk);
    dev_t = 1000; dev_f = 1000; dev_base = rd_k;
    exp_addr = AW'($urandom);
    op_addr_i = exp_addr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_o) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R9 no done after abort", int'(seen), 0);
    chk(!busy_o, "R9 idle after abort", int'(busy_o), 0);
    chk(!bus_req_o, "R9 bus quiet after abort", int'(bus_req_o), 0);
    // restart: poll count must start from zero, so a full MAXP pairs again
    run_case(1000, 1000, 0, "R9 restart");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !bus_req_o, "R1 outputs idle in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R1 busy", int'(busy_o), 0);
    chk(!done_o, "R1 done", int'(done_o), 0);
    chk(!bus_req_o, "R1 req", int'(bus_req_o), 0);
    chk(result_o == 2'd0, "R1 result", int'(result_o), 0);

    run_case(0, 99, 0, "R3 quiet first pair");
    run_case(1, 99, 0, "R4 one toggling pair");
    run_case(5, 99, 0, "R4 several pairs");
    run_case(2, 1, 0, "R5 stops on recheck");
    run_case(3, 1, 0, "R6 toggles through recheck");
    run_case(1000, 0, 0, "R6 fail at once");
    run_case(1000, 1000, 0, "R7 host timeout");
    run_case(15, 1000, 0, "R7 limit edge");
    run_case(14, 1000, 0, "R3 stop just before limit");
    run_case(1000, 0, 1, "R9 abort in write ignored");
    run_case(9, 6, 2, "R2 start while busy ignored");
    abort_then_restart();
    for (int i = 0; i < 24; i++) begin
      int t, f;
      t = int'($urandom % 24);
      f = int'($urandom % 30);
      run_case(t, f, 0, "R4 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    n_vec++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule